// File: doc/BRIEF.md
# Streaming Codeword Syndrome Calculator

This block forms the full syndrome set of a received block code over GF(2^8) in one pass. Symbols are 8 bits wide. A block is 255 symbols: 191 message symbols followed by 64 check symbols. The block takes one symbol per clock on a valid/start interface, with the coefficient of the highest power first. A bank of 64 independent accumulators runs in parallel. Each accumulator multiplies its value by its own fixed power of the primitive element and then adds the incoming symbol. All syndromes are therefore ready one clock after the final symbol is taken.

The block sits at the front of a decoder. A later stage solves for error positions and values, but only when the error flag shows that at least one syndrome is nonzero. The field multipliers are plain XOR networks. They are derived at elaboration from the field polynomial. No lookup tables are used.

Top module: `syn_calc`

## Requirements
- R1: While reset is held and after it is released, every syndrome output reads zero, and both the done pulse and the error flag stay low.
- R2: After a block, syndrome i (i = 1..64) equals the received polynomial evaluated at alpha^i. The field is defined by x^8+x^4+x^3+x^2+1 (0x11D) and alpha = 0x02. The first symbol accepted is the coefficient of x^254. Syndrome i sits in bits [8i-1 : 8i-8] of the syndrome bus.
- R3: A symbol with both valid and start high begins a new block. Any partial block is discarded. On the next cycle every syndrome equals that first symbol.
- R4: While valid is low, every syndrome holds and no done pulse appears. Start and data are ignored.
- R5: Exactly one done pulse, one cycle long, appears on the cycle after the 255th symbol of a block is accepted. A new block may begin on that same cycle.
- R6: The error flag is high exactly when at least one syndrome is nonzero. Any valid codeword (a multiple of the product of (x - alpha^i) for i = 1..64) gives all-zero syndromes and a low flag.
- R7: After the done pulse, the syndromes and the error flag hold their values until a new start is accepted. Valid symbols without start are ignored and raise no further done pulse.
- R8: Valid symbols without start that arrive after reset, before any block has begun, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| symValid | input | 1 | Symbol on symData is present this cycle |
| symStart | input | 1 | Qualifies the first symbol of a block |
| symData | input | 8 | Received symbol, highest degree first |
| syndromeFlat | output | 512 | Syndromes 1..64, syndrome i in bits [8i-1:8i-8] |
| synDone | output | 1 | One-cycle pulse when syndromes are final |
| synErr | output | 1 | High when any syndrome is nonzero |

## Verification
The syndromes, the error flag and the done pulse are all due one cycle after the edge that accepts the 255th symbol. The load of a start symbol shows up on the syndrome bus one cycle after its edge. The driver records, for each block, the cycle counter value at which done must be seen. It pushes that value together with the independently computed syndromes into a queue. The monitor samples on the falling edge and flags a done that arrives early, late or unexpected. Hold and ignore cases are checked by taking a snapshot at the done cycle and comparing it again after the ignored stimulus has passed.

// File: rtl/syn_calc_pkg.sv
`timescale 1ns/1ps
package syn_calc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // first symbol of a block: accumulators take the symbol
    logic step;   // later symbol: multiply-accumulate
  } synStrobes_t;

  localparam int GF_MAX_W = 16;

  // Generic GF(2^w) product; with one constant operand it reduces to XOR logic
  function automatic logic [GF_MAX_W-1:0] gfMulConst(
    input logic [GF_MAX_W-1:0] a,
    input logic [GF_MAX_W-1:0] b,
    input logic [GF_MAX_W:0]   poly,
    input int                  w
  );
    logic [GF_MAX_W:0]   shifted;
    logic [GF_MAX_W-1:0] prod;
    shifted = {1'b0, a};
    prod    = '0;
    for (int k = 0; k < GF_MAX_W; k++) begin
      if (k < w) begin
        if (b[k]) prod = prod ^ shifted[GF_MAX_W-1:0];
        shifted = shifted << 1;
        if (shifted[w]) shifted = shifted ^ poly;
      end
    end
    return prod;
  endfunction

  // base^e in GF(2^w)
  function automatic logic [GF_MAX_W-1:0] gfPow(
    input logic [GF_MAX_W-1:0] base,
    input int                  e,
    input logic [GF_MAX_W:0]   poly,
    input int                  w
  );
    logic [GF_MAX_W-1:0] r;
    r = GF_MAX_W'(1);
    for (int k = 0; k < e; k++) r = gfMulConst(r, base, poly, w);
    return r;
  endfunction

endpackage

// File: rtl/syn_calc_ctrl.sv
`timescale 1ns/1ps
module syn_calc_ctrl
  import syn_calc_pkg::*;
#(
  parameter int N_SYM = 255
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        symValid,
  input  logic        symStart,
  output synStrobes_t strobes,
  output logic        synDone
);

  localparam int CNT_W = $clog2(N_SYM + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_SYM - 1);

  logic [CNT_W-1:0] cntQ;
  logic             activeQ;
  logic             lastSym;

  always_comb begin
    strobes.load = symValid & symStart;
    strobes.step = symValid & ~symStart & activeQ;
    lastSym      = (strobes.load && (N_SYM == 1)) ||
                   (strobes.step && (cntQ == LAST_IDX));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      activeQ <= 1'b0;
      synDone <= 1'b0;
    end else begin
      synDone <= lastSym;
      if (strobes.load) begin
        cntQ    <= CNT_W'(1);
        activeQ <= (N_SYM != 1);
      end else if (strobes.step) begin
        cntQ    <= cntQ + CNT_W'(1);
        if (lastSym) activeQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/syn_calc_dp.sv
`timescale 1ns/1ps
module syn_calc_dp
  import syn_calc_pkg::*;
#(
  parameter int             SYM_W      = 8,
  parameter int             N_SYN      = 64,
  parameter logic [SYM_W:0] FIELD_POLY = 9'h11D,
  parameter logic [SYM_W-1:0] ALPHA    = 8'h02
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  synStrobes_t            strobes,
  input  logic [SYM_W-1:0]       symData,
  output logic [N_SYN*SYM_W-1:0] syndromeFlat,
  output logic                   synErr
);

  localparam logic [GF_MAX_W:0]   POLY_EXT  = {{(GF_MAX_W-SYM_W){1'b0}}, FIELD_POLY};
  localparam logic [GF_MAX_W-1:0] ALPHA_EXT = {{(GF_MAX_W-SYM_W){1'b0}}, ALPHA};

  for (genvar g = 0; g < N_SYN; g++) begin : g_acc
    // accumulator g holds syndrome g+1, root alpha^(g+1)
    localparam logic [GF_MAX_W-1:0] ROOT_EXT = gfPow(ALPHA_EXT, g + 1, POLY_EXT, SYM_W);
    logic [SYM_W-1:0] accQ;
    logic [SYM_W-1:0] accNext;

    always_comb begin
      accNext = SYM_W'(gfMulConst(GF_MAX_W'(accQ), ROOT_EXT, POLY_EXT, SYM_W)) ^ symData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             accQ <= '0;
      else if (strobes.load) accQ <= symData;
      else if (strobes.step) accQ <= accNext;
    end

    assign syndromeFlat[g*SYM_W +: SYM_W] = accQ;
  end

  assign synErr = |syndromeFlat;

endmodule

// File: rtl/syn_calc.sv
`timescale 1ns/1ps
module syn_calc
  import syn_calc_pkg::*;
#(
  parameter int               SYM_W      = 8,
  parameter int               N_SYM      = 255,
  parameter int               N_SYN      = 64,
  parameter logic [SYM_W:0]   FIELD_POLY = 9'h11D,
  parameter logic [SYM_W-1:0] ALPHA      = 8'h02
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   symValid,
  input  logic                   symStart,
  input  logic [SYM_W-1:0]       symData,
  output logic [N_SYN*SYM_W-1:0] syndromeFlat,
  output logic                   synDone,
  output logic                   synErr
);

  synStrobes_t strobes;

  syn_calc_ctrl #(.N_SYM(N_SYM)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .symValid (symValid),
    .symStart (symStart),
    .strobes  (strobes),
    .synDone  (synDone)
  );

  syn_calc_dp #(
    .SYM_W      (SYM_W),
    .N_SYN      (N_SYN),
    .FIELD_POLY (FIELD_POLY),
    .ALPHA      (ALPHA)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .symData      (symData),
    .syndromeFlat (syndromeFlat),
    .synErr       (synErr)
  );

endmodule

// File: rtl/syn_calc_chk.sv
`timescale 1ns/1ps
module syn_calc_chk #(
  parameter int SYM_W = 8,
  parameter int N_SYN = 64
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   symValid,
  input logic                   symStart,
  input logic [SYM_W-1:0]       symData,
  input logic [N_SYN*SYM_W-1:0] syndromeFlat,
  input logic                   synDone,
  input logic                   synErr
);

  // R3: start symbol is loaded into every accumulator
  p_load_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symStart) |=> (syndromeFlat == {N_SYN{$past(symData)}}));

  // R4: idle cycles keep state and raise no done
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> ($stable(syndromeFlat) && !synDone));

  // R5: done lasts one cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    synDone |=> !synDone);

  // R5: done only follows an accepted symbol
  p_done_after_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    synDone |-> $past(symValid));

  // R7: finished results hold unless a new block starts
  p_hold_after_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (synDone && !(symValid && symStart)) |=> ($stable(syndromeFlat) && $stable(synErr)));

endmodule

bind syn_calc syn_calc_chk #(.SYM_W(SYM_W), .N_SYN(N_SYN)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .symValid     (symValid),
  .symStart     (symStart),
  .symData      (symData),
  .syndromeFlat (syndromeFlat),
  .synDone      (synDone),
  .synErr       (synErr)
);

// File: tb/syn_calc_tb_top.sv
`timescale 1ns/1ps
module syn_calc_tb_top;

  localparam int N_SYM = 255;
  localparam int N_SYN = 64;
  localparam int BUS_W = N_SYN * 8;

  typedef struct packed {
    logic [BUS_W-1:0] syn;
    logic             err;
    logic [31:0]      due;
  } exp_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             symValid = 1'b0;
  logic             symStart = 1'b0;
  logic [7:0]       symData = 8'h00;
  logic [BUS_W-1:0] syndromeFlat;
  logic             synDone;
  logic             synErr;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [31:0] cycleCnt = 0;
  exp_t        expQ[$];
  logic [7:0]  blk [0:N_SYM-1];
  logic [7:0]  gen [0:N_SYN];

  syn_calc dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .symValid     (symValid),
    .symStart     (symStart),
    .symData      (symData),
    .syndromeFlat (syndromeFlat),
    .synDone      (synDone),
    .synErr       (synErr)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] tbMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] x, y, p;
    x = a; y = b; p = 8'h00;
    for (int k = 0; k < 8; k++) begin
      if (y[0]) p = p ^ x;
      y = y >> 1;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return p;
  endfunction

  function automatic exp_t computeExp();
    exp_t e;
    logic [7:0] root, pw, acc;
    e = '0;
    root = 8'h01;
    for (int i = 1; i <= N_SYN; i++) begin
      root = tbMul(root, 8'h02);
      pw = 8'h01; acc = 8'h00;
      for (int j = N_SYM - 1; j >= 0; j--) begin
        acc = acc ^ tbMul(blk[j], pw);
        pw  = tbMul(pw, root);
      end
      e.syn[(i-1)*8 +: 8] = acc;
    end
    e.err = (e.syn != '0);
    return e;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic buildGenerator();
    logic [7:0] root;
    for (int k = 0; k <= N_SYN; k++) gen[k] = 8'h00;
    gen[0] = 8'h01;
    root = 8'h01;
    for (int i = 1; i <= N_SYN; i++) begin
      root = tbMul(root, 8'h02);
      for (int k = i; k >= 1; k--) gen[k] = gen[k-1] ^ tbMul(gen[k], root);
      gen[0] = tbMul(gen[0], root);
    end
  endtask

  // blk[j] holds the coefficient of x^(254-j)
  task automatic fillCodeword();
    logic [7:0] msg [0:N_SYM-N_SYN-1];
    logic [7:0] c;
    for (int a = 0; a < N_SYM - N_SYN; a++) msg[a] = 8'($urandom);
    for (int d = 0; d < N_SYM; d++) begin
      c = 8'h00;
      for (int b = 0; b <= N_SYN; b++)
        if (d - b >= 0 && d - b < N_SYM - N_SYN) c = c ^ tbMul(msg[d-b], gen[b]);
      blk[N_SYM-1-d] = c;
    end
  endtask

  task automatic fillRandom();
    for (int j = 0; j < N_SYM; j++) blk[j] = 8'($urandom);
  endtask

  // Driver: sends count symbols from blk; a full block pushes its expectation
  task automatic sendBlock(input int count, input int gapEvery);
    exp_t item;
    item = computeExp();
    for (int j = 0; j < count; j++) begin
      if (gapEvery > 0 && j > 0 && (j % gapEvery) == 0) begin
        symValid = 1'b0; symStart = 1'b1; symData = 8'($urandom);
        @(negedge clk);
      end
      symValid = 1'b1; symStart = (j == 0); symData = blk[j];
      if (j == N_SYM - 1) begin
        item.due = cycleCnt + 1;
        expQ.push_back(item);
      end
      @(negedge clk);
    end
    symValid = 1'b0; symStart = 1'b0;
  endtask

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // Monitor: pops expectations on each done pulse
  always @(negedge clk) begin
    if (rstN && synDone) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 unexpected done: actual=1 expected=0 at cycle %0d", cycleCnt);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check("R5", "done cycle", BUS_W'(cycleCnt), BUS_W'(e.due));
        check("R2", "syndromes", syndromeFlat, e.syn);
        check("R6", "error flag", BUS_W'(synErr), BUS_W'(e.err));
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycleCnt == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycleCnt);
      finishRun();
    end
  end

  initial begin
    logic [BUS_W-1:0] snap;
    logic             snapErr;
    buildGenerator();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "syndromes in reset", syndromeFlat, '0);
    check("R1", "done in reset", BUS_W'(synDone), '0);
    check("R1", "err in reset", BUS_W'(synErr), '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "syndromes after reset", syndromeFlat, '0);

    // R8: valid symbols without start before any block
    for (int k = 0; k < 20; k++) begin
      symValid = 1'b1; symStart = 1'b0; symData = 8'($urandom | 1);
      @(negedge clk);
    end
    symValid = 1'b0;
    @(negedge clk);
    check("R8", "syndromes untouched", syndromeFlat, '0);
    check("R8", "err untouched", BUS_W'(synErr), '0);

    // R6: all-zero word
    for (int j = 0; j < N_SYM; j++) blk[j] = 8'h00;
    sendBlock(N_SYM, 0);
    @(negedge clk);

    // R6: valid codeword gives zero syndromes
    fillCodeword();
    sendBlock(N_SYM, 0);
    @(negedge clk);

    // R2: single symbol error at the first position
    fillCodeword();
    blk[0] = blk[0] ^ 8'h5A;
    sendBlock(N_SYM, 0);
    @(negedge clk);

    // R2: burst of 32 errors mid-block, with idle gaps (R4)
    fillCodeword();
    for (int j = 100; j < 132; j++) blk[j] = blk[j] ^ 8'hFF;
    sendBlock(N_SYM, 7);

    // R7: hold after done while unstarted symbols arrive
    snap = syndromeFlat; snapErr = synErr;
    for (int k = 0; k < 8; k++) begin
      symValid = 1'b1; symStart = 1'b0; symData = 8'($urandom);
      @(negedge clk);
    end
    for (int k = 0; k < 3; k++) begin
      symValid = 1'b0; symStart = 1'b1; symData = 8'($urandom);
      @(negedge clk);
    end
    symStart = 1'b0;
    check("R7", "syndromes held", syndromeFlat, snap);
    check("R7", "err held", BUS_W'(synErr), BUS_W'(snapErr));

    // R3: start symbol loaded into every accumulator
    symValid = 1'b1; symStart = 1'b1; symData = 8'hA5;
    @(negedge clk);
    symValid = 1'b0; symStart = 1'b0;
    check("R3", "first symbol load", syndromeFlat, {N_SYN{8'hA5}});
    // R4: idle keeps the loaded values even with start high
    symStart = 1'b1; symData = 8'h3C;
    repeat (4) @(negedge clk);
    symStart = 1'b0;
    check("R4", "idle hold", syndromeFlat, {N_SYN{8'hA5}});

    // R3: restart discards a partial block
    fillRandom();
    sendBlock(100, 0);
    fillRandom();
    sendBlock(N_SYM, 0);
    @(negedge clk);

    // R5: back-to-back blocks, new start on the done cycle
    fillRandom();
    sendBlock(N_SYM, 0);
    fillCodeword();
    blk[254] = blk[254] ^ 8'h01;
    sendBlock(N_SYM, 13);
    repeat (5) @(negedge clk);

    check("R5", "all blocks reported", BUS_W'(expQ.size()), '0);
    finishRun();
  end

endmodule